// File: doc/BRIEF.md
# Reset Strap Sampling Controller

This block takes a snapshot of a handful of board-level configuration straps at the moment the system reset input is released. It keeps that snapshot as steady mode outputs until the next release. Straps driven at other times have no effect. The snapshot holds four things:

- a two-pin core-to-bus clock ratio select, decoded into a ratio code;
- a request for tri-state test mode;
- a request for built-in self-test;
- an enable for an optional scatter/gather pin group.

The block runs on its own clock and has an asynchronous active-low power-on reset. Every external input, the system reset included, passes through a two-flop synchronizer before any decision is taken. The block detects the high-to-low transition of the synchronized system reset and captures the synchronized straps in that cycle. A valid flag then tells downstream logic that the mode outputs may be used. While the system reset is active, and through the capture cycle, an identification output is held high so that board logic can recognise the device type.

Top module: `rsc_strap_sampler`

## Requirements
- R1: After power-on reset, and before any system reset release has been seen, the outputs are: `straps_valid`=0, `ratio_sel`=2'b10, `ratio_half`=4, `tristate_test`=0, `self_test`=0, `sg_enable`=0 and `id_drive`=1. The ratio value is the default that floating ratio pins give.
- R2: The ratio select is {`ratio_pin_hi`,`ratio_pin_lo`} and appears unchanged on `ratio_sel`. `ratio_half` gives twice the core-to-bus ratio, as follows:

  | Select | Ratio | `ratio_half` |
  |---|---|---|
  | 00 | 2.5 | 5 |
  | 01 | 3.0 | 6 |
  | 10 | 2.0 | 4 |
  | 11 | 3.5 | 7 |

- R3: Straps are captured only on the high-to-low transition of `sys_reset`. Changes to strap inputs after the capture leave every mode output unchanged.
- R4: If `cache_flush_n` is captured low, `tristate_test` is 1. If it is captured high, `tristate_test` is 0.
- R5: If `warm_init` is captured high and `cache_flush_n` is captured high, `self_test` is 1. If `warm_init` is captured low, `self_test` is 0.
- R6: If `cache_flush_n` is captured low and `warm_init` is captured high, `tristate_test` is 1 and `self_test` is 0.
- R7: If `sg_strap_n` is captured low, `sg_enable` is 1. If it is captured high, `sg_enable` is 0.
- R8: `id_drive` is 1 while the synchronized system reset is high, and stays 1 through the cycle in which `straps_valid` rises. It is 0 from the following cycle until reset is asserted again.
- R9: When `sys_reset` is asserted again, `straps_valid` goes to 0. The mode outputs keep their previous capture until the next release.
- R10: `straps_valid` and the newly captured mode outputs change on the third rising clock edge after `sys_reset` falls. They have not changed after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside the block |
| sys_reset | input | 1 | Active-high system reset; its release triggers the strap capture |
| ratio_pin_hi | input | 1 | Upper bit of the clock ratio strap |
| ratio_pin_lo | input | 1 | Lower bit of the clock ratio strap |
| cache_flush_n | input | 1 | Active-low cache flush request, used as the tri-state test strap |
| warm_init | input | 1 | Active-high warm-reset request, used as the self-test strap |
| sg_strap_n | input | 1 | Active-low scatter/gather pin group enable strap |
| ratio_sel | output | 2 | Captured ratio select |
| ratio_half | output | 4 | Captured core-to-bus ratio times two |
| tristate_test | output | 1 | Tri-state test mode requested |
| self_test | output | 1 | Built-in self-test requested |
| sg_enable | output | 1 | Scatter/gather pin group enabled |
| id_drive | output | 1 | Identification level, high through reset release |
| straps_valid | output | 1 | Mode outputs hold a capture from the latest reset release |

## Verification
The bench boots the block once for each of the four ratio select codes, so every decode value is shown to be distinct. It then boots with each test request on its own, and with both together. This separates the individual decodes from the priority rule. It also boots with the scatter/gather strap both low and high.

Each boot checks `straps_valid` one edge before and on the edge where it is due. This tells a correct synchronizer depth from one that is too short or too long. A separate sequence moves the straps after capture and then reasserts reset while different straps are applied. This tells a capture taken only on the edge apart from a continuous transparent latch, and shows that mode outputs are kept while reset is active again.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int RATIO_W = 2;
  localparam int HALF_W  = 4;
  localparam int PIN_W   = 6;

  localparam logic [RATIO_W-1:0] RATIO_DEFAULT = 2'b10;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio_sel;
    logic               flush_req;
    logic               warm_req;
    logic               sg_req;
  } strap_t;

  function automatic logic [HALF_W-1:0] ratio_to_half(input logic [RATIO_W-1:0] sel);
    logic [HALF_W-1:0] r;
    case (sel)
      2'b00:   r = 4'd5;
      2'b01:   r = 4'd6;
      2'b10:   r = 4'd4;
      default: r = 4'd7;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= RESET_VAL;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rsc_reset_edge.sv
module rsc_reset_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_level,
  output logic fall,
  output logic id_drive
);

  logic level_d_q, level_d_nxt;
  logic id_q, id_nxt;

  always_comb begin
    level_d_nxt = rst_level;
    id_nxt      = rst_level | level_d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_d_q <= 1'b1;
      id_q      <= 1'b1;
    end else begin
      level_d_q <= level_d_nxt;
      id_q      <= id_nxt;
    end
  end

  assign fall     = level_d_q & ~rst_level;
  assign id_drive = id_q;

  // R8: identification held high while reset is seen active
  p_id_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_level |=> id_drive);

  // R3: a release produces exactly one capture pulse
  p_single_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/rsc_strap_latch.sv
module rsc_strap_latch
  import rsc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   capture,
  input  logic   rst_level,
  input  strap_t straps,
  output strap_t held,
  output logic   valid
);

  strap_t held_q, held_nxt;
  logic   valid_q, valid_nxt;
  logic   load_en;

  assign load_en = capture;

  always_comb begin
    held_nxt  = held_q;
    valid_nxt = valid_q;
    if (load_en) begin
      held_nxt.ratio_sel = straps.ratio_sel;
      held_nxt.flush_req = straps.flush_req;
      held_nxt.warm_req  = straps.warm_req & ~straps.flush_req;
      held_nxt.sg_req    = straps.sg_req;
      valid_nxt          = 1'b1;
    end else if (rst_level) begin
      valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q.ratio_sel <= RATIO_DEFAULT;
      held_q.flush_req <= 1'b0;
      held_q.warm_req  <= 1'b0;
      held_q.sg_req    <= 1'b0;
      valid_q          <= 1'b0;
    end else begin
      held_q  <= held_nxt;
      valid_q <= valid_nxt;
    end
  end

  assign held  = held_q;
  assign valid = valid_q;

  // R3: captured modes move only on a capture pulse
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held_q));

  // R6: the two test requests never leave together
  p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(held_q.flush_req && held_q.warm_req));

  // R10: valid follows a capture pulse on the next edge
  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> valid_q);

endmodule

// File: rtl/rsc_strap_sampler.sv
module rsc_strap_sampler
  import rsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_reset,
  input  logic              ratio_pin_hi,
  input  logic              ratio_pin_lo,
  input  logic              cache_flush_n,
  input  logic              warm_init,
  input  logic              sg_strap_n,
  output logic [RATIO_W-1:0] ratio_sel,
  output logic [HALF_W-1:0]  ratio_half,
  output logic              tristate_test,
  output logic              self_test,
  output logic              sg_enable,
  output logic              id_drive,
  output logic              straps_valid
);

  localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, RATIO_DEFAULT, 1'b1, 1'b0, 1'b1};

  logic             rst_n;
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             rst_level, fall;
  strap_t           straps_now, held;

  // synchronous release of the power-on reset
  rsc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_por_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (1'b1),
    .q     (rst_n)
  );

  assign pins_raw = {sys_reset, ratio_pin_hi, ratio_pin_lo, cache_flush_n, warm_init, sg_strap_n};

  rsc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign rst_level            = pins_s[5];
  assign straps_now.ratio_sel = pins_s[4:3];
  assign straps_now.flush_req = ~pins_s[2];
  assign straps_now.warm_req  = pins_s[1];
  assign straps_now.sg_req    = ~pins_s[0];

  rsc_reset_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_level (rst_level),
    .fall      (fall),
    .id_drive  (id_drive)
  );

  rsc_strap_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (fall),
    .rst_level (rst_level),
    .straps    (straps_now),
    .held      (held),
    .valid     (straps_valid)
  );

  assign ratio_sel     = held.ratio_sel;
  assign ratio_half    = ratio_to_half(held.ratio_sel);
  assign tristate_test = held.flush_req;
  assign self_test     = held.warm_req;
  assign sg_enable     = held.sg_req;

  // R9: a reasserted reset withdraws the valid flag
  p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_level && !fall) |=> !straps_valid);

  // R8: identification is low whenever valid has been up a cycle
  p_id_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (straps_valid && $past(straps_valid) && !rst_level) |-> !id_drive);

endmodule

// File: tb/rsc_strap_sampler_tb.sv
module rsc_strap_sampler_tb;

  logic       clk = 1'b0;
  logic       por_n, sys_reset, ratio_pin_hi, ratio_pin_lo;
  logic       cache_flush_n, warm_init, sg_strap_n;
  logic [1:0] ratio_sel;
  logic [3:0] ratio_half;
  logic       tristate_test, self_test, sg_enable, id_drive, straps_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  rsc_strap_sampler u_dut (
    .clk(clk), .por_n(por_n), .sys_reset(sys_reset),
    .ratio_pin_hi(ratio_pin_hi), .ratio_pin_lo(ratio_pin_lo),
    .cache_flush_n(cache_flush_n), .warm_init(warm_init), .sg_strap_n(sg_strap_n),
    .ratio_sel(ratio_sel), .ratio_half(ratio_half), .tristate_test(tristate_test),
    .self_test(self_test), .sg_enable(sg_enable), .id_drive(id_drive),
    .straps_valid(straps_valid)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  task automatic set_straps(input logic [1:0] sel, input logic fl_n, input logic wi, input logic sg_n);
    ratio_pin_hi  = sel[1];
    ratio_pin_lo  = sel[0];
    cache_flush_n = fl_n;
    warm_init     = wi;
    sg_strap_n    = sg_n;
  endtask

  // full reset pulse; returns at the negedge after valid rose
  task automatic boot(input logic [1:0] sel, input logic fl_n, input logic wi, input logic sg_n);
    @(negedge clk);
    set_straps(sel, fl_n, wi, sg_n);
    sys_reset = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 valid low in reset", {3'b0, straps_valid}, 4'd0);
    check("R8 id high in reset", {3'b0, id_drive}, 4'd1);
    sys_reset = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10 valid not yet after 2 edges", {3'b0, straps_valid}, 4'd0);
    @(posedge clk); @(negedge clk);
    check("R10 valid on 3rd edge", {3'b0, straps_valid}, 4'd1);
    check("R8 id high in capture cycle", {3'b0, id_drive}, 4'd1);
  endtask

  task automatic t_reset_defaults();
    check("R1 valid", {3'b0, straps_valid}, 4'd0);
    check("R1 ratio_sel", {2'b0, ratio_sel}, 4'd2);
    check("R1 ratio_half", ratio_half, 4'd4);
    check("R1 tristate", {3'b0, tristate_test}, 4'd0);
    check("R1 selftest", {3'b0, self_test}, 4'd0);
    check("R1 sg", {3'b0, sg_enable}, 4'd0);
    check("R1 id", {3'b0, id_drive}, 4'd1);
  endtask

  task automatic t_ratio();
    for (int i = 0; i < 4; i++) begin
      logic [3:0] exp_half;
      case (i)
        0: exp_half = 4'd5;
        1: exp_half = 4'd6;
        2: exp_half = 4'd4;
        default: exp_half = 4'd7;
      endcase
      boot(i[1:0], 1'b1, 1'b0, 1'b1);
      check("R2 ratio_sel", {2'b0, ratio_sel}, i[3:0]);
      check("R2 ratio_half", ratio_half, exp_half);
      @(negedge clk);
      check("R8 id low after capture", {3'b0, id_drive}, 4'd0);
    end
  endtask

  task automatic t_modes();
    boot(2'b10, 1'b0, 1'b0, 1'b1);
    check("R4 tristate on flush", {3'b0, tristate_test}, 4'd1);
    check("R4 no selftest", {3'b0, self_test}, 4'd0);
    check("R7 sg off when strap high", {3'b0, sg_enable}, 4'd0);
    boot(2'b10, 1'b1, 1'b1, 1'b1);
    check("R5 selftest on warm", {3'b0, self_test}, 4'd1);
    check("R4 tristate off", {3'b0, tristate_test}, 4'd0);
    boot(2'b10, 1'b0, 1'b1, 1'b1);
    check("R6 tristate wins", {3'b0, tristate_test}, 4'd1);
    check("R6 selftest suppressed", {3'b0, self_test}, 4'd0);
    boot(2'b10, 1'b1, 1'b0, 1'b0);
    check("R7 sg on when strap low", {3'b0, sg_enable}, 4'd1);
    check("R5 selftest off", {3'b0, self_test}, 4'd0);
  endtask

  task automatic t_hold();
    boot(2'b11, 1'b0, 1'b0, 1'b0);
    set_straps(2'b00, 1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check("R3 ratio held", ratio_half, 4'd7);
    check("R3 tristate held", {3'b0, tristate_test}, 4'd1);
    check("R3 selftest held", {3'b0, self_test}, 4'd0);
    check("R3 sg held", {3'b0, sg_enable}, 4'd1);
    sys_reset = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 valid drops on reassert", {3'b0, straps_valid}, 4'd0);
    check("R9 ratio kept in reset", ratio_half, 4'd7);
    check("R9 sg kept in reset", {3'b0, sg_enable}, 4'd1);
    sys_reset = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 new capture ratio", ratio_half, 4'd5);
    check("R3 new capture selftest", {3'b0, self_test}, 4'd1);
    check("R3 new capture valid", {3'b0, straps_valid}, 4'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    por_n     = 1'b0;
    sys_reset = 1'b1;
    set_straps(2'b10, 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset_defaults();
    t_ratio();
    t_modes();
    t_hold();
    report();
  end

endmodule